// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block picks which interrupt source a processor core serves next. Each source either latches an event into a pending flag or requests only while its input is high. Each source has its own enable, and one global enable gates them all. When a source is pending and enabled and the global enable is set, the controller emits a one-cycle take strobe. The strobe carries the vector number of the winning source and the program address of that vector.

The core drives commands into the controller: return-from-interrupt, set-global-enable and clear-global-enable, plus a pulse for each instruction it retires. After a return, no interrupt is accepted until the core has retired at least one more instruction. Software clears latched flags by writing ones. A single select input moves the vector addresses into a boot region.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source i maps to vector i+1. Vector 0 is reserved for reset and is never emitted. When several sources qualify in the same cycle, the lowest source index wins.
- R2: A source is taken only when its bit in `src_en` is 1 and the global enable is 1.
- R3: The global enable resets to 0. A take clears it. `cmd_cli` also clears it. `cmd_sei` or `cmd_reti` sets it. When a take, `cmd_cli` and a set command fall in the same cycle, the clear wins.
- R4: A latched source's flag (bit i of `irq_flags`) sets on a high `src_in[i]` whether or not the source is enabled, and it stays set. A 1 in `flag_clr_data[i]` while `flag_clr_wr` is high clears the flag. A new event in the same cycle as that clear leaves the flag set.
- R5: Taking a latched source clears its flag at the same edge that raises `irq_take`.
- R6: A level source (a 1 in the `LEVEL_MASK` parameter, default bits 5 and 7) has no flag. It requests only while `src_in[i]` is high, so a request that ends before the source is enabled is never taken.
- R7: After `cmd_reti`, no take occurs until the cycle after the first cycle that is later than the return and has `insn_retired` high.
- R8: `cmd_cli` blocks a take in its own cycle, even when a request and the global enable are present in that cycle.
- R9: Setting the global enable inside a handler allows any enabled pending source to be taken again (nesting).
- R10: `irq_addr` equals `(boot_sel ? BOOT_BASE : 0) + (vector << STRIDE_SH)`. The defaults are a base of 0xC00 and a shift of 1.
- R11: `irq_take` is registered. It is high for exactly one cycle, in the cycle after the one in which the source qualified.
- R12: After reset, `irq_take`, `irq_gie` and `irq_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N_SRC | Event pulses for latched sources, condition levels for level sources |
| src_en | input | N_SRC | Per-source enables |
| flag_clr_wr | input | 1 | Write strobe for clearing flags |
| flag_clr_data | input | N_SRC | Each 1 clears the matching latched flag |
| cmd_sei | input | 1 | Set global enable |
| cmd_cli | input | 1 | Clear global enable, effective in the same cycle |
| cmd_reti | input | 1 | Return from interrupt |
| insn_retired | input | 1 | One main-program instruction retired |
| boot_sel | input | 1 | Place vectors in the boot region |
| irq_take | output | 1 | One-cycle take strobe |
| irq_idx | output | IDX_W | Vector number of the taken source |
| irq_addr | output | ADDR_W | Vector address of the taken source |
| irq_gie | output | 1 | Global enable state |
| irq_flags | output | N_SRC | Latched pending flags |

## Verification
A stuck global enable or return-hold state shows up at the ports as a take strobe that appears or goes missing within one cycle of the next qualifying request. A lost or stale pending flag shows up on `irq_flags` at the next edge, and as a wrong vector number on the next take. The bench runs a behavioural reference model every clock and compares strobe, vector, address, global enable and flags. This catches any divergence in the cycle it first appears.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 8'hA0,
  parameter int ADDR_W = 12,
  parameter int STRIDE_SH = 1,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hC00,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic [N_SRC-1:0]  src_en,
  input  logic              flag_clr_wr,
  input  logic [N_SRC-1:0]  flag_clr_data,
  input  logic              cmd_sei,
  input  logic              cmd_cli,
  input  logic              cmd_reti,
  input  logic              insn_retired,
  input  logic              boot_sel,
  output logic              irq_take,
  output logic [IDX_W-1:0]  irq_idx,
  output logic [ADDR_W-1:0] irq_addr,
  output logic              irq_gie,
  output logic [N_SRC-1:0]  irq_flags
);

  logic [N_SRC-1:0] flag_q, flag_d, req, elig, lowbit, take_clr;
  logic             gie_q, hold_q, win_ok, accept;
  logic [IDX_W-1:0] win_idx;

  assign req    = (flag_q & ~LEVEL_MASK) | (src_in & LEVEL_MASK);
  assign elig   = req & src_en;
  assign lowbit = elig & (~elig + N_SRC'(1));

  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win_ok  = 1'b1;
        win_idx = IDX_W'(i + 1);
      end
    end
  end

  assign accept   = win_ok & gie_q & ~cmd_cli & ~hold_q;
  assign take_clr = accept ? lowbit : '0;
  assign flag_d   = ((flag_q & ~(flag_clr_wr ? flag_clr_data : '0) & ~take_clr) | src_in)
                    & ~LEVEL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= '0;
      gie_q    <= 1'b0;
      hold_q   <= 1'b0;
      irq_take <= 1'b0;
      irq_idx  <= '0;
      irq_addr <= '0;
    end else begin
      flag_q   <= flag_d;
      irq_take <= accept;
      if (accept) begin
        irq_idx  <= win_idx;
        irq_addr <= (boot_sel ? BOOT_BASE : '0) + (ADDR_W'(win_idx) << STRIDE_SH);
      end
      if (accept || cmd_cli)       gie_q <= 1'b0;
      else if (cmd_sei || cmd_reti) gie_q <= 1'b1;
      if (cmd_reti)          hold_q <= 1'b1;
      else if (insn_retired) hold_q <= 1'b0;
    end
  end

  assign irq_gie   = gie_q;
  assign irq_flags = flag_q;

  AST_VEC0_NEVER:   assert property (@(posedge clk) disable iff (!rst_n) irq_take |-> (irq_idx != '0 && irq_idx <= IDX_W'(N_SRC))); // R1
  AST_NEED_GIE:     assert property (@(posedge clk) disable iff (!rst_n) irq_take |-> $past(gie_q)); // R2
  AST_TAKE_DROPS:   assert property (@(posedge clk) disable iff (!rst_n) irq_take |-> !gie_q); // R3
  AST_RETI_WAIT:    assert property (@(posedge clk) disable iff (!rst_n) hold_q |=> !irq_take); // R7
  AST_CLI_BLOCKS:   assert property (@(posedge clk) disable iff (!rst_n) cmd_cli |=> !irq_take); // R8
  AST_ONE_CYCLE:    assert property (@(posedge clk) disable iff (!rst_n) irq_take |=> !irq_take); // R11
  AST_LEVEL_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n) (irq_flags & LEVEL_MASK) == '0); // R6

endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/100ps
module irq_vector_ctrl_test;
  localparam int N = 8;
  localparam logic [N-1:0] LVL = 8'hA0;
  localparam int BASE = 'hC00;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_in = 0, src_en = 0, clr_data = 0;
  logic clr_wr = 0, sei = 0, cli = 0, reti = 0, retired = 0, boot = 0;
  logic take; logic [3:0] idx; logic [11:0] addr; logic gie; logic [N-1:0] flags;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_en(src_en),
    .flag_clr_wr(clr_wr), .flag_clr_data(clr_data),
    .cmd_sei(sei), .cmd_cli(cli), .cmd_reti(reti), .insn_retired(retired),
    .boot_sel(boot), .irq_take(take), .irq_idx(idx), .irq_addr(addr),
    .irq_gie(gie), .irq_flags(flags));

  // behavioural reference model
  int m_flag[N];
  int m_gie, m_hold, m_take, m_idx, m_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_flag[i]) m_flag[i] = 0;
      m_gie = 0; m_hold = 0; m_take = 0;
    end else begin
      int win;
      int tk;
      win = -1;
      for (int i = 0; i < N; i++) begin
        int r;
        r = LVL[i] ? int'(src_in[i]) : m_flag[i];
        if (r != 0 && src_en[i] && win < 0) win = i;
      end
      tk = (m_gie != 0 && !cli && m_hold == 0 && win >= 0) ? 1 : 0;
      for (int i = 0; i < N; i++) begin
        if (LVL[i]) m_flag[i] = 0;
        else begin
          if (clr_wr && clr_data[i]) m_flag[i] = 0;
          if (tk != 0 && win == i) m_flag[i] = 0;
          if (src_in[i]) m_flag[i] = 1;
        end
      end
      if (tk != 0) begin
        m_idx = win + 1;
        m_addr = (boot ? BASE : 0) + (m_idx * 2);
      end
      m_take = tk;
      if (tk != 0 || cli) m_gie = 0;
      else if (sei || reti) m_gie = 1;
      if (reti) m_hold = 1;
      else if (retired) m_hold = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mflags();
    int v = 0;
    for (int i = 0; i < N; i++) if (m_flag[i] != 0) v |= (1 << i);
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
    check("R11 take", int'(take), m_take);
    if (m_take != 0) begin
      check("R1 vector", int'(idx), m_idx);
      check("R10 address", int'(addr), m_addr);
    end
    check("R3 gie", int'(gie), m_gie);
    check("R4 flags", int'(flags), mflags());
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R12 take", int'(take), 0);
    check("R12 gie", int'(gie), 0);
    check("R12 flags", int'(flags), 0);

    // R4: flag latches while disabled
    src_in = 8'h08; tick(); src_in = 0;
    check("R4 set", int'(flags), 8'h08);
    repeat (3) tick();
    check("R4 held", int'(flags), 8'h08);

    // R2: gie alone is not enough
    sei = 1; tick(); sei = 0;
    check("R3 sei", int'(gie), 1);
    tick(); tick();
    check("R2 disabled", int'(take), 0);
    src_en = 8'h08; tick();
    check("R2 taken", int'(take), 1);
    check("R1 idx", int'(idx), 4);
    check("R10 addr", int'(addr), 8);
    check("R5 flag cleared", int'(flags), 0);
    check("R3 take clears", int'(gie), 0);
    tick();
    check("R11 single", int'(take), 0);

    // R1 priority, R7 return hold
    src_en = 8'h5F; src_in = 8'h44; tick(); src_in = 0;
    sei = 1; tick(); sei = 0;
    tick();
    check("R1 lowest wins", int'(idx), 3);
    check("R1 take", int'(take), 1);
    reti = 1; tick(); reti = 0;
    check("R3 reti sets", int'(gie), 1);
    tick(); tick();
    check("R7 hold", int'(take), 0);
    retired = 1; tick(); retired = 0;
    check("R7 retire cycle", int'(take), 0);
    tick();
    check("R7 after retire", int'(take), 1);
    check("R7 idx", int'(idx), 7);

    // R9 nesting
    src_in = 8'h01; tick(); src_in = 0;
    tick();
    check("R9 no take gie 0", int'(take), 0);
    sei = 1; tick(); sei = 0;
    tick();
    check("R9 nested take", int'(take), 1);
    check("R9 idx", int'(idx), 1);

    // R8 cli same cycle
    src_en = 8'h20;
    sei = 1; tick(); sei = 0;
    src_in = 8'h20; cli = 1; tick(); cli = 0; src_in = 0;
    check("R8 blocked", int'(take), 0);
    check("R8 gie", int'(gie), 0);
    tick();
    check("R8 no late take", int'(take), 0);

    // R6 level source vanishes before enable
    src_en = 0; sei = 1; tick(); sei = 0;
    src_in = 8'h80; tick(); tick(); src_in = 0; tick();
    src_en = 8'h80; tick(); tick();
    check("R6 no take", int'(take), 0);
    check("R6 no flag", int'(flags), 0);
    src_in = 8'h80; tick(); src_in = 0;
    check("R6 take", int'(take), 1);
    check("R6 idx", int'(idx), 8);

    // R10 boot region
    boot = 1; src_in = 8'h02; src_en = 8'h02; sei = 1; tick(); src_in = 0; sei = 0;
    tick();
    check("R10 boot take", int'(take), 1);
    check("R10 boot addr", int'(addr), BASE + 4);
    boot = 0;

    // R4 write-one-to-clear and event precedence
    src_en = 0; src_in = 8'h10; clr_wr = 1; clr_data = 8'h10; tick(); src_in = 0;
    check("R4 event wins", int'(flags), 8'h10);
    tick(); clr_wr = 0; clr_data = 0;
    check("R4 w1c", int'(flags), 0);

    // mixed traffic checked against the model
    for (int k = 0; k < 4000; k++) begin
      src_in  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      if (($urandom % 16) == 0) src_en = 8'($urandom);
      clr_wr  = (($urandom % 8) == 0); clr_data = 8'($urandom);
      sei     = (($urandom % 6) == 0);
      cli     = (($urandom % 10) == 0);
      reti    = (($urandom % 12) == 0);
      retired = (($urandom % 3) == 0);
      boot    = (($urandom % 32) == 0) ? ~boot : boot;
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule